// File: doc/BRIEF.md
# Silicon Strip Hit Cluster Finder

The block receives one discriminated hit bit per strip for a row of silicon strips on every bunch crossing, one vector per clock. It removes strips flagged in a per-strip suppression mask, groups adjacent hit strips into clusters, and discards every cluster wider than a programmable limit. For each cluster that survives, it reports the cluster centre in half-strip units. An odd-width cluster therefore lands on a strip, and an even-width cluster lands between two strips.

The hit bits of the strips just beyond each edge of the row come from the adjacent chips. This lets the block measure a cluster that straddles a chip boundary at its true width. Such a cluster is reported by exactly one chip: the one that owns the centre position.

Processing runs in three pipeline stages: capture and masking, a per-strip local cluster decision, and a global collection stage. The collection stage lists up to eight centres per crossing in ascending order and raises an overflow flag when more clusters were found.

Top module: `strip_cluster_finder`

## Requirements
- R1: A strip whose bit in `sup_mask_i` is 1 is treated as not hit, whatever its hit bit is. The suppression applies only to this chip's strips, not to the edge bits from the neighbouring chips.
- R2: A cluster is a maximal run of adjacent hit strips, from first strip f to last strip l. Its reported position is f+l in half-strip units, so strip n alone reports 2n.
- R3: `wmax_code_i` selects the width limit as code+1, giving 1 to 4 strips. A cluster wider than the limit produces no entry at all. The width code and the suppression mask are sampled on the same edge as the hit vector they apply to.
- R4: Bit k of `edge_lo_i` is the hit of strip −(k+1), and bit k of `edge_hi_i` is the hit of strip N+k, where N is the strip count. These bits take part in cluster forming and width measurement. A cluster is reported only if its position f+l lies in 0..2N−1.
- R5: A new hit vector is accepted on every clock edge. Its result appears on the outputs after the third rising edge, counting the one that samples it. Back-to-back vectors do not disturb each other.
- R6: Accepted clusters fill slots 0 upward in strictly increasing position order. Slot k's position is `clu_pos_o[7k+6:7k]`, and `clu_valid_o` is a contiguous run of ones starting at bit 0.
- R7: When more than eight clusters are accepted, the eight lowest positions are reported and `clu_ovf_o` is 1. Otherwise `clu_ovf_o` is 0.
- R8: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 64 | Discriminated hit bit per strip |
| sup_mask_i | input | 64 | 1 suppresses a dead or noisy strip |
| edge_lo_i | input | 4 | Hits of the four strips below strip 0, from the lower neighbour chip |
| edge_hi_i | input | 4 | Hits of the four strips above the last strip, from the upper neighbour chip |
| wmax_code_i | input | 2 | Width limit minus one |
| clu_valid_o | output | 8 | Slot occupancy |
| clu_pos_o | output | 56 | Eight 7-bit half-strip positions |
| clu_ovf_o | output | 1 | More than eight clusters accepted |

## Verification
The hardest cases to reach from the ports are the ownership decisions at the chip edges. In these, a cluster's fate depends jointly on neighbour bits, on the chip's own first or last strips and on the width limit. For example, a three-wide run starting at strip −1 must be reported at position 0, while a two-wide one is given away to the neighbour. The stimulus walks every combination of the four neighbour bits with the three outermost own strips on both edges, and sweeps a single run of every width 1 to 6 across every start position under all four width codes. A stream of randomly generated vectors, each with its own mask and width code, checks that per-vector configuration travels with its data.

// File: rtl/clf_pkg.sv
package clf_pkg;
  // Widest cluster the hardware can accept; also the depth of neighbour data per edge.
  localparam int CLF_WMAX  = 4;
  localparam int CLF_WCODE = 2;

  // Number of consecutive ones starting at bit 0, saturating at CLF_WMAX+1.
  function automatic int unsigned run_from(input logic [CLF_WMAX:0] win);
    int unsigned n;
    bit go;
    n  = 0;
    go = 1'b1;
    for (int b = 0; b <= CLF_WMAX; b++) begin
      if (!win[b]) go = 1'b0;
      if (go) n++;
    end
    return n;
  endfunction

  function automatic int unsigned width_limit(input logic [CLF_WCODE-1:0] code);
    return int'(code) + 1;
  endfunction

  // Half-strip centre of a run starting at strip 'first' with 'len' strips.
  function automatic int centre_half(input int first, input int len);
    return 2 * first + len - 1;
  endfunction
endpackage

// File: rtl/clf_ingest.sv
module clf_ingest
  import clf_pkg::*;
#(
  parameter int NSTRIP = 64,
  localparam int NB    = CLF_WMAX,
  localparam int NEXT  = NSTRIP + 2 * NB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTRIP-1:0]    hit_i,
  input  logic [NSTRIP-1:0]    mask_i,
  input  logic [NB-1:0]        lo_i,
  input  logic [NB-1:0]        hi_i,
  input  logic [CLF_WCODE-1:0] code_i,
  output logic [NEXT-1:0]      ext_q,
  output logic [CLF_WCODE-1:0] code_q
);
  logic [NEXT-1:0] ext_d;

  // Extended index j holds strip j-NB.
  assign ext_d[NB+NSTRIP-1:NB] = hit_i & ~mask_i;
  for (genvar k = 0; k < NB; k++) begin : g_edges
    assign ext_d[NB-1-k]      = lo_i[k];
    assign ext_d[NB+NSTRIP+k] = hi_i[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      code_q <= '0;
    end else begin
      ext_q  <= ext_d;
      code_q <= code_i;
    end
  end
endmodule

// File: rtl/clf_local.sv
module clf_local
  import clf_pkg::*;
#(
  parameter int NSTRIP = 64,
  localparam int NB    = CLF_WMAX,
  localparam int NEXT  = NSTRIP + 2 * NB,
  localparam int NHALF = 2 * NSTRIP,
  localparam int HW    = $clog2(NHALF),
  localparam int LW    = $clog2(CLF_WMAX + 2),
  localparam int NCAND = NSTRIP + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEXT-1:0]      ext_i,
  input  logic [CLF_WCODE-1:0] code_i,
  output logic [NHALF-1:0]     cen_q
);
  logic [NCAND-1:0] open_ok;
  logic [LW-1:0]    open_len [NCAND];
  logic [NHALF-1:0] cen_d;
  int unsigned      lim;

  assign lim = width_limit(code_i);

  // Candidate a opens a run at strip a-1 (extended index j = a+NB-1).
  for (genvar a = 0; a < NCAND; a++) begin : g_cand
    localparam int J = a + NB - 1;
    int unsigned run;
    assign run         = run_from(ext_i[J+CLF_WMAX:J]);
    assign open_len[a] = LW'(run);
    assign open_ok[a]  = ext_i[J] & ~ext_i[J-1] & (run <= lim);
  end

  // Only the centre half-strip of an accepted cluster is marked.
  always_comb begin
    int p;
    cen_d = '0;
    for (int a = 0; a < NCAND; a++) begin
      for (int l = 1; l <= CLF_WMAX; l++) begin
        p = centre_half(a - 1, l);
        if (open_ok[a] && int'(open_len[a]) == l && p >= 0 && p < NHALF)
          cen_d[p[HW-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cen_q <= '0;
    else        cen_q <= cen_d;
  end
endmodule

// File: rtl/clf_gather.sv
module clf_gather #(
  parameter int NSTRIP = 64,
  parameter int NOUT   = 8,
  localparam int NHALF = 2 * NSTRIP,
  localparam int PW    = $clog2(NSTRIP) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NHALF-1:0]   cen_i,
  output logic [NOUT-1:0]    valid_q,
  output logic [NOUT*PW-1:0] pos_q,
  output logic               ovf_q
);
  logic [NOUT-1:0]    valid_d;
  logic [NOUT*PW-1:0] pos_d;
  logic               ovf_d;

  // Repeatedly take the lowest marked centre and clear it.
  always_comb begin
    logic [NHALF-1:0] rem;
    logic [PW-1:0]    idx;
    logic             found;
    rem     = cen_i;
    valid_d = '0;
    pos_d   = '0;
    for (int k = 0; k < NOUT; k++) begin
      found = 1'b0;
      idx   = '0;
      for (int i = NHALF - 1; i >= 0; i--) begin
        if (rem[i]) begin
          idx   = PW'(i);
          found = 1'b1;
        end
      end
      if (found) begin
        valid_d[k]          = 1'b1;
        pos_d[k*PW +: PW]   = idx;
        rem[idx]            = 1'b0;
      end
    end
    ovf_d = |rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      pos_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      pos_q   <= pos_d;
      ovf_q   <= ovf_d;
    end
  end
endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder
  import clf_pkg::*;
#(
  parameter int NSTRIP = 64,
  parameter int NOUT   = 8,
  localparam int NB    = CLF_WMAX,
  localparam int NEXT  = NSTRIP + 2 * NB,
  localparam int NHALF = 2 * NSTRIP,
  localparam int PW    = $clog2(NSTRIP) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSTRIP-1:0]    hit_i,
  input  logic [NSTRIP-1:0]    sup_mask_i,
  input  logic [NB-1:0]        edge_lo_i,
  input  logic [NB-1:0]        edge_hi_i,
  input  logic [CLF_WCODE-1:0] wmax_code_i,
  output logic [NOUT-1:0]      clu_valid_o,
  output logic [NOUT*PW-1:0]   clu_pos_o,
  output logic                 clu_ovf_o
);
  logic [NEXT-1:0]      ext_q;
  logic [CLF_WCODE-1:0] code_q;
  logic [NHALF-1:0]     cen_q;   // accepted centres, one bit per half-strip

  clf_ingest #(.NSTRIP(NSTRIP)) u_ingest (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .mask_i(sup_mask_i),
    .lo_i(edge_lo_i), .hi_i(edge_hi_i), .code_i(wmax_code_i),
    .ext_q(ext_q), .code_q(code_q)
  );

  clf_local #(.NSTRIP(NSTRIP)) u_local (
    .clk(clk), .rst_n(rst_n), .ext_i(ext_q), .code_i(code_q), .cen_q(cen_q)
  );

  clf_gather #(.NSTRIP(NSTRIP), .NOUT(NOUT)) u_gather (
    .clk(clk), .rst_n(rst_n), .cen_i(cen_q),
    .valid_q(clu_valid_o), .pos_q(clu_pos_o), .ovf_q(clu_ovf_o)
  );
endmodule

// File: rtl/strip_cluster_finder_chk.sv
module strip_cluster_finder_chk #(
  parameter int NSTRIP = 64,
  parameter int NOUT   = 8,
  localparam int NHALF = 2 * NSTRIP,
  localparam int PW    = $clog2(NSTRIP) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NHALF-1:0]   cen,
  input logic [NOUT-1:0]    valid,
  input logic [NOUT*PW-1:0] pos,
  input logic               ovf
);
  assert_fill_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid + NOUT'(1)) & valid) == '0);

  for (genvar k = 0; k < NOUT - 1; k++) begin : g_order
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid[k+1] |-> (pos[(k+1)*PW +: PW] > pos[k*PW +: PW]));
  end

  assert_ovf_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (&valid));

  assert_ovf_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cen) > NOUT) |=> ovf);

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cen == '0) |=> (valid == '0 && !ovf));

  assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cen != '0) |=> valid[0]);
endmodule

bind strip_cluster_finder strip_cluster_finder_chk #(.NSTRIP(NSTRIP), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen(cen_q),
  .valid(clu_valid_o), .pos(clu_pos_o), .ovf(clu_ovf_o)
);

// File: tb/strip_cluster_finder_test.sv
`timescale 1ns/1ps
module strip_cluster_finder_test;
  localparam int N  = 64;
  localparam int NO = 8;
  localparam int PW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] hit = '0, msk = '0;
  logic [3:0] lo = '0, hi = '0;
  logic [1:0] code = '0;
  logic [NO-1:0] v_o;
  logic [NO*PW-1:0] p_o;
  logic o_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [NO-1:0]    rv [4];
  logic [NO*PW-1:0] rp [4];
  logic             ro [4];
  string            rt [4];

  always #2.5 clk = ~clk;

  strip_cluster_finder uut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .sup_mask_i(msk),
    .edge_lo_i(lo), .edge_hi_i(hi), .wmax_code_i(code),
    .clu_valid_o(v_o), .clu_pos_o(p_o), .clu_ovf_o(o_o)
  );

  // Reference: scan runs over strips -4..N+3 and apply width and ownership rules.
  task automatic model(input logic [N-1:0] h, m, input logic [3:0] l, u,
                       input logic [1:0] c, output logic [NO-1:0] ev,
                       output logic [NO*PW-1:0] ep, output logic eo);
    bit x [N+8];
    int i, e, w, pp, n;
    for (int k = 0; k < 4; k++) begin
      x[3-k]   = l[k];
      x[N+4+k] = u[k];
    end
    for (int s = 0; s < N; s++) x[s+4] = h[s] & ~m[s];
    ev = '0; ep = '0; eo = 1'b0; n = 0; i = 0;
    while (i < N + 8) begin
      if (x[i]) begin
        e = i;
        while (e + 1 < N + 8 && x[e+1]) e++;
        w  = e - i + 1;
        pp = (i - 4) + (e - 4);
        if (w <= int'(c) + 1 && pp >= 0 && pp < 2 * N) begin
          if (n < NO) begin
            ev[n] = 1'b1;
            ep[n*PW +: PW] = PW'(pp);
            n++;
          end else eo = 1'b1;
        end
        i = e + 1;
      end else i++;
    end
  endtask

  task automatic compare(input string tag, input logic [NO-1:0] ev,
                         input logic [NO*PW-1:0] ep, input logic eo);
    logic [NO*PW-1:0] ap;
    ap = '0;
    for (int k = 0; k < NO; k++) if (v_o[k]) ap[k*PW +: PW] = p_o[k*PW +: PW];
    checks++;
    if (v_o !== ev || ap !== ep || o_o !== eo) begin
      errors++;
      $display("FAIL %s valid=%b/%b ovf=%b/%b pos=%h/%h", tag, v_o, ev, o_o, eo, ap, ep);
    end
  endtask

  // One crossing: check the vector issued three cycles ago, then drive a new one.
  task automatic step(input logic [N-1:0] h, m, input logic [3:0] l, u,
                      input logic [1:0] c, input string tag);
    logic [NO-1:0] ev; logic [NO*PW-1:0] ep; logic eo;
    @(negedge clk);
    if (cyc >= 3) compare({tag == "" ? "R5" : rt[(cyc-3)%4]}, rv[(cyc-3)%4], rp[(cyc-3)%4], ro[(cyc-3)%4]);
    model(h, m, l, u, c, ev, ep, eo);
    rv[cyc%4] = ev; rp[cyc%4] = ep; ro[cyc%4] = eo; rt[cyc%4] = (tag == "") ? "R5" : tag;
    hit = h; msk = m; lo = l; hi = u; code = c;
    cyc++;
  endtask

  task automatic flush();
    for (int k = 0; k < 3; k++) step('0, '0, '0, '0, 2'd0, "R5 flush");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] h, m;
    // R8: outputs stay zero in reset even with busy inputs
    hit = 64'h0000_0000_0000_0111; code = 2'd3;
    repeat (4) @(negedge clk);
    compare("R8 reset", '0, '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    compare("R8 after release", '0, '0, 1'b0);

    // R2 R3: single run of every width at every start, all width codes
    for (int c = 0; c < 4; c++)
      for (int st = 0; st < N; st++)
        for (int w = 1; w <= 6; w++) begin
          h = '0;
          for (int b = st; b < st + w && b < N; b++) h[b] = 1'b1;
          step(h, '0, '0, '0, 2'(c), "R2 R3 single run");
        end

    // R1: suppress each strip of a repeating three-wide pattern
    for (int i = 0; i < N; i++) begin
      m = '0; m[i] = 1'b1;
      step({16{4'b0111}}, m, '0, '0, 2'd2, "R1 mask");
    end
    // R1: mask splits an over-wide run into two acceptable ones
    step(64'h0000_0000_0001_FF00, 64'h0000_0000_0000_1000, '0, '0, 2'd3, "R1 split");
    // R1: neighbour bits not subject to mask
    step(64'h1, 64'h1, 4'h3, '0, 2'd3, "R1 edge unmasked");

    // R4: every neighbour pattern against the outermost own strips on both edges
    for (int c = 1; c < 4; c += 2)
      for (int nb = 0; nb < 16; nb++)
        for (int own = 0; own < 8; own++) begin
          h = '0;
          h[2:0] = 3'(own);
          step(h, '0, 4'(nb), '0, 2'(c), "R4 low edge");
          h = '0;
          h[N-1:N-3] = 3'(own);
          step(h, '0, '0, 4'(nb), 2'(c), "R4 high edge");
        end

    // R6 R7: growing number of isolated single-strip clusters
    for (int n = 0; n <= 20; n++) begin
      h = '0;
      for (int k = 0; k < n; k++) h[3*k] = 1'b1;
      step(h, '0, '0, '0, 2'd0, "R6 R7 count");
    end
    step({32{2'b01}}, '0, '0, '0, 2'd0, "R7 alternating");
    step({32{2'b10}}, '0, 4'h1, 4'h0, 2'd1, "R6 R7 alternating shifted");

    // R5: back-to-back random vectors with per-vector configuration
    for (int k = 0; k < 400; k++) begin
      h = {$urandom, $urandom};
      if (k % 3 == 0) h = h & {$urandom, $urandom};
      m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      step(h, m, 4'($urandom), 4'($urandom), 2'($urandom), "R5 stream");
    end
    flush();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule